// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block sits in the transmit path between the MAC-side transmit enable and the line driver of a 10 Mb/s twisted-pair port. It measures how long transmit enable stays high. If one burst runs past a fixed number of clock cycles, the block forces the driver enable low and raises a jabber flag. The lockout holds for as long as the stuck enable stays high. It is released only after the enable has stayed low without a break for a second, much longer interval, called the unjab interval.

Both intervals are parameters counted in clock cycles. The defaults correspond to roughly 85 ms and 500 ms at 100 MHz, and a bench can shrink them. When the 10 Mb/s mode select is low, the watchdog is inactive: the enable passes straight through and no jabber is flagged.

The controller has four states:
- `JS_IDLE`: passing, enable low.
- `JS_SEND`: passing, burst being timed.
- `JS_CUT`: locked out, enable still high.
- `JS_UNJAB`: locked out, low time being timed.

Its transitions are:
- IDLE→SEND on a high enable in 10 Mb/s mode.
- SEND→IDLE when the enable drops.
- SEND→CUT when the burst reaches the limit.
- CUT→UNJAB when the enable drops.
- UNJAB→CUT when the enable rises again.
- UNJAB→IDLE when the unjab interval completes.
- Any state→IDLE when the mode select goes low.

Top module: `txjab_guard`

## Requirements
- R1: In 10 Mb/s mode, `tx_en_o` equals `tx_en_i` during the first ON_LIMIT consecutive high cycles of a burst. It is low in every later cycle of the same burst, so `tx_en_o` is never high for more than ON_LIMIT cycles in a row.
- R2: `jab_flag_o` rises in the cycle after the ON_LIMIT-th consecutive high cycle of `tx_en_i`. A burst of exactly ON_LIMIT cycles trips the flag, and a burst of ON_LIMIT-1 cycles does not.
- R3: While `jab_flag_o` is high, `tx_en_o` is low. As long as `tx_en_i` stays high, `jab_flag_o` stays high.
- R4: Once `tx_en_i` falls after a cutoff, `jab_flag_o` clears, and `tx_en_o` again follows `tx_en_i`, in the cycle after IDLE_LIMIT consecutive low cycles of `tx_en_i`, and not earlier.
- R5: A high `tx_en_i` at any point during the unjab interval, including its final cycle, keeps `tx_en_o` low. It also restarts the unjab interval from zero once the enable falls again.
- R6: The burst timer restarts from zero on every new burst. Bursts of ON_LIMIT-1 cycles separated by a single low cycle never trip the flag.
- R7: With `mode_10m_i` low, `tx_en_o` equals `tx_en_i` in the same cycle and `jab_flag_o` is low. Any lockout in progress is abandoned, so a burst that starts after the mode returns to 10 Mb/s is timed from zero.
- R8: An active-low reset, applied asynchronously, returns the block to IDLE. During and after reset `jab_flag_o` is low, and a burst still in progress when reset is released is timed from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_10m_i | input | 1 | 1 = 10 Mb/s operation, watchdog active; 0 = pass-through |
| tx_en_i | input | 1 | Transmit enable from the MAC side |
| tx_en_o | output | 1 | Gated transmit enable to the line driver |
| jab_flag_o | output | 1 | Jabber status, high from cutoff until re-enable |

## Verification
The sharpest coincidence is the end of the unjab interval landing in the same cycle as a renewed transmit enable. Release and restart then compete, and restart must win. The stimulus raises the enable exactly in the last low cycle of the interval and requires the output to stay gated with the flag held. A second coincidence comes from bursts of ON_LIMIT-1 and ON_LIMIT cycles that end at the timer boundary, where the falling enable and the cutoff meet. The first length must pass cleanly and the second must trip the flag.

// File: rtl/txjab_pkg.sv
package txjab_pkg;

    // Controller states of the jabber watchdog.
    typedef enum logic [1:0] {
        JS_IDLE  = 2'd0,   // passing, enable low
        JS_SEND  = 2'd1,   // passing, burst being timed
        JS_CUT   = 2'd2,   // locked out, enable still high
        JS_UNJAB = 2'd3    // locked out, quiet time being timed
    } jab_state_e;

    // Index of each span timer inside the timer array.
    localparam int unsigned TMR_BURST = 0;
    localparam int unsigned TMR_QUIET = 1;
    localparam int unsigned TMR_COUNT = 2;

endpackage

// File: rtl/txjab_span_ctr.sv
// Span timer: loads to one, steps by one, flags the cycle before its limit.
module txjab_span_ctr #(
    parameter int unsigned LIMIT = 8,
    parameter int unsigned WIDTH = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic step_i,
    output logic last_o
);

    localparam logic [WIDTH-1:0] LAST_VAL = WIDTH'(LIMIT - 1);
    localparam logic [WIDTH-1:0] ONE_VAL  = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= ONE_VAL;
        end else if (step_i) begin
            cnt_q <= cnt_q + ONE_VAL;
        end
    end

    assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/txjab_fsm.sv
// Four-state lockout controller.
module txjab_fsm
    import txjab_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       mode_i,
    input  logic       tx_i,
    input  logic       burst_last_i,
    input  logic       quiet_last_i,
    output jab_state_e state_o,
    output logic       burst_load_o,
    output logic       burst_step_o,
    output logic       quiet_load_o,
    output logic       quiet_step_o
);

    jab_state_e state_q;
    jab_state_e state_d;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= JS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            JS_IDLE: begin
                if (mode_i && tx_i) state_d = JS_SEND;
            end
            JS_SEND: begin
                if (!mode_i || !tx_i)   state_d = JS_IDLE;
                else if (burst_last_i)  state_d = JS_CUT;
            end
            JS_CUT: begin
                if (!mode_i)            state_d = JS_IDLE;
                else if (!tx_i)         state_d = JS_UNJAB;
            end
            JS_UNJAB: begin
                if (!mode_i)            state_d = JS_IDLE;
                else if (tx_i)          state_d = JS_CUT;
                else if (quiet_last_i)  state_d = JS_IDLE;
            end
            default: state_d = JS_IDLE;
        endcase
    end

    // Timer controls.
    always_comb begin
        burst_load_o = 1'b0;
        burst_step_o = 1'b0;
        quiet_load_o = 1'b0;
        quiet_step_o = 1'b0;
        unique case (state_q)
            JS_IDLE:  burst_load_o = mode_i && tx_i;
            JS_SEND:  burst_step_o = mode_i && tx_i && !burst_last_i;
            JS_CUT:   quiet_load_o = mode_i && !tx_i;
            JS_UNJAB: quiet_step_o = mode_i && !tx_i && !quiet_last_i;
            default: ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/txjab_gate.sv
// Output stage: gates the driver enable and produces the status flag.
module txjab_gate
    import txjab_pkg::*;
(
    input  logic       mode_i,
    input  logic       tx_i,
    input  jab_state_e state_i,
    output logic       tx_o,
    output logic       flag_o
);

    always_comb begin
        tx_o   = tx_i;
        flag_o = 1'b0;
        if (mode_i) begin
            unique case (state_i)
                JS_IDLE, JS_SEND: begin
                    tx_o   = tx_i;
                    flag_o = 1'b0;
                end
                JS_CUT, JS_UNJAB: begin
                    tx_o   = 1'b0;
                    flag_o = 1'b1;
                end
                default: begin
                    tx_o   = 1'b0;
                    flag_o = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/txjab_guard.sv
// Transmit jabber watchdog, top level.
module txjab_guard
    import txjab_pkg::*;
#(
    parameter int unsigned ON_LIMIT   = 8_500_000,
    parameter int unsigned IDLE_LIMIT = 50_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_10m_i,
    input  logic tx_en_i,
    output logic tx_en_o,
    output logic jab_flag_o
);

    localparam int unsigned MAX_LIMIT = (ON_LIMIT > IDLE_LIMIT) ? ON_LIMIT : IDLE_LIMIT;
    localparam int unsigned CTR_W     = $clog2(MAX_LIMIT + 1);

    jab_state_e           state;
    logic [TMR_COUNT-1:0] tmr_load;
    logic [TMR_COUNT-1:0] tmr_step;
    logic [TMR_COUNT-1:0] tmr_last;

    txjab_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mode_i       (mode_10m_i),
        .tx_i         (tx_en_i),
        .burst_last_i (tmr_last[TMR_BURST]),
        .quiet_last_i (tmr_last[TMR_QUIET]),
        .state_o      (state),
        .burst_load_o (tmr_load[TMR_BURST]),
        .burst_step_o (tmr_step[TMR_BURST]),
        .quiet_load_o (tmr_load[TMR_QUIET]),
        .quiet_step_o (tmr_step[TMR_QUIET])
    );

    for (genvar g = 0; g < TMR_COUNT; g++) begin : g_tmr
        localparam int unsigned LIM = (g == TMR_BURST) ? ON_LIMIT : IDLE_LIMIT;
        txjab_span_ctr #(
            .LIMIT (LIM),
            .WIDTH (CTR_W)
        ) u_ctr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .load_i (tmr_load[g]),
            .step_i (tmr_step[g]),
            .last_o (tmr_last[g])
        );
    end

    txjab_gate u_gate (
        .mode_i  (mode_10m_i),
        .tx_i    (tx_en_i),
        .state_i (state),
        .tx_o    (tx_en_o),
        .flag_o  (jab_flag_o)
    );

endmodule

// File: rtl/txjab_guard_chk.sv
// Property checker, attached to every txjab_guard instance.
module txjab_guard_chk #(
    parameter int unsigned ON_LIMIT = 8
) (
    input logic clk_i,
    input logic rst_ni,
    input logic mode_10m_i,
    input logic tx_en_i,
    input logic tx_en_o,
    input logic jab_flag_o
);

    localparam int unsigned RUN_W = $clog2(ON_LIMIT + 1) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(ON_LIMIT);

    // Consecutive gated-high cycles seen so far in 10 Mb/s mode.
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= '0;
        end else if (mode_10m_i && tx_en_o) begin
            if (run_q < RUN_MAX) run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_10m_i && tx_en_o) |-> (run_q < RUN_MAX)); // R1

    AST_TRIP_AFTER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(jab_flag_o) |-> ($past(tx_en_i) && $past(mode_10m_i))); // R2

    AST_GATED_WHILE_JAB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jab_flag_o |-> !tx_en_o); // R3

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (jab_flag_o && tx_en_i && mode_10m_i) |=> (jab_flag_o || !mode_10m_i)); // R5

    AST_RELEASE_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(jab_flag_o) && mode_10m_i && $past(mode_10m_i)) |-> !$past(tx_en_i)); // R4

    AST_PASS_OTHER_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_10m_i |-> ((tx_en_o == tx_en_i) && !jab_flag_o)); // R7

endmodule

bind txjab_guard txjab_guard_chk #(
    .ON_LIMIT (ON_LIMIT)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_10m_i (mode_10m_i),
    .tx_en_i    (tx_en_i),
    .tx_en_o    (tx_en_o),
    .jab_flag_o (jab_flag_o)
);

// File: tb/txjab_guard_bench.sv
module txjab_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ON_LIM     = 8;
    localparam int IDLE_LIM   = 12;

    typedef struct packed {
        logic       mode;
        logic       tx;
        logic [7:0] len;
        logic       exp_out;
        logic       exp_flag;
        logic [3:0] req;
    } seg_t;

    localparam int NSEG = 23;
    localparam seg_t SEGS [NSEG] = '{
        '{1'b1, 1'b0, 8'd3,  1'b0, 1'b0, 4'd8},  // R8 quiet after reset
        '{1'b1, 1'b1, 8'd7,  1'b1, 1'b0, 4'd2},  // R2 burst of ON_LIM-1 passes
        '{1'b1, 1'b0, 8'd1,  1'b0, 1'b0, 4'd6},  // R6 single low gap
        '{1'b1, 1'b1, 8'd7,  1'b1, 1'b0, 4'd6},  // R6 timer restarted
        '{1'b1, 1'b0, 8'd1,  1'b0, 1'b0, 4'd6},
        '{1'b1, 1'b1, 8'd8,  1'b1, 1'b0, 4'd1},  // R1 first ON_LIM cycles pass
        '{1'b1, 1'b1, 8'd5,  1'b0, 1'b1, 4'd3},  // R3 cut and held while high
        '{1'b1, 1'b0, 8'd11, 1'b0, 1'b1, 4'd4},  // R4 not yet released
        '{1'b1, 1'b1, 8'd2,  1'b0, 1'b1, 4'd5},  // R5 rise in final unjab cycle
        '{1'b1, 1'b0, 8'd12, 1'b0, 1'b1, 4'd5},  // R5 interval restarted
        '{1'b1, 1'b0, 8'd2,  1'b0, 1'b0, 4'd4},  // R4 released
        '{1'b1, 1'b1, 8'd3,  1'b1, 1'b0, 4'd4},  // R4 passing again
        '{1'b1, 1'b0, 8'd2,  1'b0, 1'b0, 4'd4},
        '{1'b0, 1'b1, 8'd20, 1'b1, 1'b0, 4'd7},  // R7 no limit in other mode
        '{1'b0, 1'b0, 8'd2,  1'b0, 1'b0, 4'd7},
        '{1'b1, 1'b1, 8'd8,  1'b1, 1'b0, 4'd1},  // R1
        '{1'b1, 1'b1, 8'd2,  1'b0, 1'b1, 4'd2},  // R2 tripped
        '{1'b0, 1'b1, 8'd3,  1'b1, 1'b0, 4'd7},  // R7 lockout abandoned
        '{1'b1, 1'b1, 8'd3,  1'b1, 1'b0, 4'd7},  // R7 fresh burst timing
        '{1'b1, 1'b0, 8'd2,  1'b0, 1'b0, 4'd7},
        '{1'b1, 1'b1, 8'd8,  1'b1, 1'b0, 4'd2},  // R2 burst of exactly ON_LIM
        '{1'b1, 1'b0, 8'd12, 1'b0, 1'b1, 4'd2},  // R2 flagged, R4 full interval
        '{1'b1, 1'b0, 8'd1,  1'b0, 1'b0, 4'd4}   // R4 released
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_r = 1'b1;
    logic tx_r = 1'b0;
    logic tx_out;
    logic jab;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txjab_guard #(
        .ON_LIMIT   (ON_LIM),
        .IDLE_LIMIT (IDLE_LIM)
    ) u_txjab_guard (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_10m_i (mode_r),
        .tx_en_i    (tx_r),
        .tx_en_o    (tx_out),
        .jab_flag_o (jab)
    );

    task automatic check(input logic exp_out, input logic exp_flag, input int req);
        total++;
        if (tx_out !== exp_out) begin
            bad++;
            $display("FAIL R%0d tx_en_o actual=%b expected=%b at %0t", req, tx_out, exp_out, $time);
        end
        total++;
        if (jab !== exp_flag) begin
            bad++;
            $display("FAIL R%0d jab_flag_o actual=%b expected=%b at %0t", req, jab, exp_flag, $time);
        end
    endtask

    task automatic step(input logic m, input logic t, input logic eo, input logic ef, input int req);
        @(negedge clk);
        mode_r = m;
        tx_r   = t;
        #1;
        check(eo, ef, req);
    endtask

    initial begin
        // R8 reset state.
        @(negedge clk);
        tx_r = 1'b1;
        #1;
        check(1'b1, 1'b0, 8);
        tx_r = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < int'(SEGS[s].len); c++) begin
                step(SEGS[s].mode, SEGS[s].tx, SEGS[s].exp_out, SEGS[s].exp_flag, int'(SEGS[s].req));
            end
        end

        // R8 reset in the middle of a lockout.
        for (int c = 0; c < ON_LIM; c++) step(1'b1, 1'b1, 1'b1, 1'b0, 1);
        step(1'b1, 1'b1, 1'b0, 1'b1, 3);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1'b1, 1'b0, 8);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1'b1, 1'b0, 8);
        for (int c = 1; c < ON_LIM; c++) step(1'b1, 1'b1, 1'b1, 1'b0, 8);
        step(1'b1, 1'b1, 1'b0, 1'b1, 8);
        step(1'b1, 1'b0, 1'b0, 1'b1, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule